// File: doc/BRIEF.md
# Reset Extension Timer

This block holds the processor core in reset for a fixed interval after the external master-clear pin goes high, and again after every watchdog time-out. The interval gives the supply time to settle and the main oscillator time to reach stable oscillation before any instruction runs. A watchdog expiry, including one that wakes the core from sleep, therefore always gets the full start-up delay.

The timer is clocked by its own free-running internal RC clock, not by the main oscillator, so it keeps counting when the main clock is stopped. The delay is a parameter given in cycles of that clock. The nominal target is about 18 ms; the default value of 18000 assumes a 1 MHz timer clock. The master-clear level is asynchronous and passes through a two-stage synchronizer. The watchdog time-out is a one-cycle pulse that is already synchronous to the timer clock. The power-on reset is a synchronous, active-low input.

Top module: `rdt_reset_timer`

## Requirements
- R1: While `rst_n` is low, `core_rst` is 1. After `rst_n` goes high, `core_rst` stays 1 until a delay has run to completion.
- R2: `mclr_in` passes through exactly two synchronizer flops before the trigger logic sees it. A change of `mclr_in` that is captured at rising edge n therefore acts at edge n+2.
- R3: While the synchronized master-clear is low:
  - the counter is held at zero;
  - `core_rst` is 1;
  - a low pulse during a running delay aborts that delay, and the full delay restarts when the level returns high.
- R4: The delay is triggered at the first edge T at which the synchronized master-clear is seen high. `core_rst` then stays 1 and goes to 0 after edge T+DELAY_CYCLES. So when `mclr_in` goes high before edge n, `core_rst` falls after edge n+DELAY_CYCLES+2.
- R5: Suppose `wdt_timeout` is 1 at edge w while master-clear is high and the delay has already finished. Then `core_rst` is 1 from edge w and falls after edge w+DELAY_CYCLES.
- R6: A `wdt_timeout` pulse at edge w during a running delay restarts the count. Release then happens after edge w+DELAY_CYCLES.
- R7: A `wdt_timeout` pulse while the synchronized master-clear is low has no effect: `core_rst` stays 1 and the later release timing follows R4.
- R8: Once released, `core_rst` stays 0 until a watchdog time-out or a low synchronized master-clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Free-running internal timer clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| mclr_in | input | 1 | External master-clear level, asynchronous, high = run |
| wdt_timeout | input | 1 | Watchdog time-out pulse, one cycle, synchronous to clk_rc |
| core_rst | output | 1 | Registered reset to the core, active high |

## Verification
Each result falls on a fixed edge:
- A master-clear change captured at edge n first acts at edge n+2, and a master-clear rise releases `core_rst` after edge n+DELAY_CYCLES+2.
- A watchdog pulse sampled at edge w raises `core_rst` from that edge and releases it after edge w+DELAY_CYCLES.

The bench drives inputs on falling edges and samples `core_rst` on the next falling edge. Directed checks count whole clock cycles from the driving edge to the release and compare the count with these formulas. A reference model built from the requirements advances once per rising edge and is compared with the output every cycle during random stimulus.

// File: rtl/rdt_pkg.sv
// Package: shared types for the reset extension timer.
// Assumes: included in compile order before all rdt_* modules.
package rdt_pkg;

    // Sequencer state of the delay counter.
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,   // master-clear low or power-on: counter parked at zero
        ST_COUNT = 2'd1,   // delay running, core held in reset
        ST_RUN   = 2'd2    // delay complete, core released
    } rdt_state_e;

endpackage

// File: rtl/rdt_sync.sv
// Module: rdt_sync
// Multi-stage level synchronizer for one asynchronous input.
// Assumes: the input is a slow level (no pulses shorter than STAGES clocks);
// synchronous active-low reset clears every stage to 0.
module rdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] stage_q;

    // First stage captures the raw asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= din;
    end

    // Remaining stages shift the captured level along the chain.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= 1'b0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/rdt_trigger.sv
// Module: rdt_trigger
// Turns the synchronized master-clear level and the watchdog pulse into
// hold and start requests for the delay counter.
// Assumes: mclr_s is already synchronous; wdt_pulse is a synchronous one-cycle pulse.
// A start is raised on the first cycle master-clear is seen high (also right
// after power-on with master-clear already high) and on every watchdog pulse
// while master-clear is high; hold wins over everything.
module rdt_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic mclr_s,
    input  logic wdt_pulse,
    output logic hold_req,
    output logic start_req
);

    logic mclr_prev_q;
    logic mclr_rise;

    // Remember last cycle's synchronized level for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mclr_prev_q <= 1'b0;
        else        mclr_prev_q <= mclr_s;
    end

    // Derive rise, hold and start requests.
    always_comb begin
        mclr_rise = mclr_s & ~mclr_prev_q;
        hold_req  = ~mclr_s;
        start_req = mclr_s & (mclr_rise | wdt_pulse);
    end

endmodule

// File: rtl/rdt_counter.sv
// Module: rdt_counter
// Delay sequencer: counts DELAY_CYCLES clocks after each start and drives a
// registered, glitch-free reset output.
// Assumes: hold_req has priority over start_req; DELAY_CYCLES >= 2.
module rdt_counter
    import rdt_pkg::*;
#(
    parameter int DELAY_CYCLES = 18000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic start_req,
    output logic rst_o
);

    localparam int CW = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [CW-1:0] TERM = CW'(DELAY_CYCLES - 1);

    rdt_state_e    state_q, state_nxt;
    logic [CW-1:0] cnt_q, cnt_nxt;

    // Next-state and next-count decision; hold beats start beats counting.
    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        if (hold_req) begin
            state_nxt = ST_HOLD;
            cnt_nxt   = '0;
        end else if (start_req) begin
            state_nxt = ST_COUNT;
            cnt_nxt   = '0;
        end else begin
            case (state_q)
                ST_COUNT: begin
                    if (cnt_q == TERM) begin
                        state_nxt = ST_RUN;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt_q + CW'(1);
                    end
                end
                ST_RUN:  state_nxt = ST_RUN;
                default: state_nxt = ST_HOLD;
            endcase
        end
    end

    // State, count and reset-output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            rst_o   <= 1'b1;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
            rst_o   <= (state_nxt != ST_RUN);
        end
    end

    // R4: the count never passes the terminal value.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM);

    // R3: a hold request parks the counter at zero with reset asserted.
    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> (cnt_q == '0) && rst_o);

    // R6: a start (watchdog or master-clear rise) restarts from zero in reset.
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !hold_req) |=> (cnt_q == '0) && rst_o && (state_q == ST_COUNT));

    // R4: reset is released only right after the terminal count.
    assert_release_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> ($past(cnt_q) == TERM) && ($past(state_q) == ST_COUNT));

endmodule

// File: rtl/rdt_reset_timer.sv
// Module: rdt_reset_timer (top)
// Reset extension timer: holds core_rst high while master-clear is low and
// for DELAY_CYCLES timer clocks after master-clear rises or a watchdog times out.
// Assumes: clk_rc is the free-running internal RC clock; rst_n is a synchronous
// active-low power-on reset; wdt_timeout is synchronous to clk_rc.
module rdt_reset_timer #(
    parameter int DELAY_CYCLES = 18000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk_rc,
    input  logic rst_n,
    input  logic mclr_in,
    input  logic wdt_timeout,
    output logic core_rst
);

    logic mclr_s;
    logic hold_req;
    logic start_req;

    rdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_rc),
        .rst_n (rst_n),
        .din   (mclr_in),
        .dout  (mclr_s)
    );

    rdt_trigger u_trigger (
        .clk       (clk_rc),
        .rst_n     (rst_n),
        .mclr_s    (mclr_s),
        .wdt_pulse (wdt_timeout),
        .hold_req  (hold_req),
        .start_req (start_req)
    );

    rdt_counter #(.DELAY_CYCLES(DELAY_CYCLES)) u_counter (
        .clk       (clk_rc),
        .rst_n     (rst_n),
        .hold_req  (hold_req),
        .start_req (start_req),
        .rst_o     (core_rst)
    );

    // R8: once released, reset stays low without a hold or start.
    assert_stay_released_R8: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (!core_rst && !hold_req && !start_req) |=> !core_rst);

    // R7: a watchdog pulse during hold cannot take the core out of reset.
    assert_wdt_ignored_R7: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (hold_req && wdt_timeout) |=> core_rst);

endmodule

// File: tb/test_rdt_reset_timer.sv
module test_rdt_reset_timer;

    localparam int D = 37;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclr_in = 1'b0;
    logic wdt_timeout = 1'b0;
    logic core_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rdt_reset_timer #(.DELAY_CYCLES(D)) i_rdt_reset_timer (
        .clk_rc      (clk),
        .rst_n       (rst_n),
        .mclr_in     (mclr_in),
        .wdt_timeout (wdt_timeout),
        .core_rst    (core_rst)
    );

    // Reference model built from R1-style rules: two sync stages, hold while low,
    // delay of D edges from the trigger edge.
    bit m1 = 0, m2 = 0, mp = 0, mhold = 1;
    int left = 0;
    bit exp_rst = 1;
    bit model_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 0; m2 = 0; mp = 0; mhold = 1; left = 0;
        end else begin
            if (!m2) begin
                mhold = 1; left = 0;
            end else if (wdt_timeout || !mp) begin
                mhold = 0; left = D;
            end else if (left > 0) begin
                left = left - 1;
            end
            mp = m2; m2 = m1; m1 = mclr_in;
        end
        exp_rst = !rst_n || mhold || (left > 0);
        cycles++;
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            checks++;
            if (core_rst !== exp_rst) begin
                errors++;
                $display("FAIL R4 model compare: core_rst=%0b expected %0b at cycle %0d",
                         core_rst, exp_rst, cycles);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: run did not end");
            finish_run();
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Count ticks until core_rst reads 0 (bounded).
    task automatic ticks_to_release(output int n);
        n = 0;
        while (core_rst && n < 4 * D) begin
            tick();
            n++;
        end
    endtask

    function automatic int exp_mclr_release(input int delay);
        return delay + 3;   // R4: edges n..n+delay+2
    endfunction

    function automatic int exp_wdt_release(input int delay);
        return delay;       // R5/R6: after edge w, D further edges
    endfunction

    task automatic pulse_wdt();
        wdt_timeout = 1'b1;
        tick();
        wdt_timeout = 1'b0;
    endtask

    int n;

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R1: reset state
        repeat (3) tick();
        check("R1 core_rst during power-on reset", core_rst, 1);
        model_on = 1;
        rst_n = 1'b1;
        repeat (50) tick();
        check("R1 reset held after power-on with mclr low", core_rst, 1);
        check("R3 reset held while mclr low", core_rst, 1);

        // R2 R4: master-clear rise
        mclr_in = 1'b1;
        ticks_to_release(n);
        check("R2 R4 release ticks after mclr rise", n, exp_mclr_release(D));

        // R8: stays released
        repeat (100) tick();
        check("R8 still released", core_rst, 0);

        // R5: watchdog after release
        pulse_wdt();
        check("R5 reset asserted at wdt edge", core_rst, 1);
        ticks_to_release(n);
        check("R5 release ticks after wdt", n, exp_wdt_release(D));

        // R6: watchdog during running delay
        pulse_wdt();
        repeat (15) tick();
        pulse_wdt();
        ticks_to_release(n);
        check("R6 release ticks after restart", n, exp_wdt_release(D));

        // R3: mclr low pulse mid-count restarts full delay
        pulse_wdt();
        repeat (10) tick();
        mclr_in = 1'b0;
        repeat (5) tick();
        check("R3 reset held during mclr low", core_rst, 1);
        mclr_in = 1'b1;
        ticks_to_release(n);
        check("R3 full delay after mclr returns", n, exp_mclr_release(D));

        // R7: watchdog while mclr low is ignored
        mclr_in = 1'b0;
        repeat (5) tick();
        pulse_wdt();
        repeat (2 * D) tick();
        check("R7 wdt ignored while mclr low", core_rst, 1);
        mclr_in = 1'b1;
        ticks_to_release(n);
        check("R7 release after mclr rise", n, exp_mclr_release(D));

        // R1: power-on reset with mclr already high
        rst_n = 1'b0;
        tick();
        check("R1 reset asserted by rst_n", core_rst, 1);
        rst_n = 1'b1;
        ticks_to_release(n);
        check("R1 R4 release after power-on with mclr high", n, exp_mclr_release(D));

        // Random phase, checked by the model every cycle (R4 R5 R6 R3).
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 299) == 0) mclr_in = ~mclr_in;
            wdt_timeout = ($urandom_range(0, 79) == 0);
            tick();
        end
        wdt_timeout = 1'b0;
        mclr_in = 1'b1;
        repeat (3 * D) tick();
        check("R8 final released state", core_rst, 0);

        finish_run();
    end

endmodule